// File: doc/BRIEF.md
# Bus-Borrowing DMA Channel Controller

This block is a single-channel DMA engine. It moves bytes between one I/O port and a run of memory locations without the host processor taking part. When its peripheral raises a request, the channel asks the processor for the system bus through a hold request. It waits for the hold acknowledge and then drives the memory address together with paired memory and I/O strobes, so that each byte passes straight from one side to the other. Each byte transfer takes three bus cycles: address setup, strobe, and release. The peripheral acknowledge is held high for all three.

The host programs the channel through a small write port. The port holds a base address, a base count and a mode word. The mode word selects the direction, address increment or decrement, single or block servicing, and automatic reload. A programmed count of N moves N+1 bytes. The terminal-count output pulses on the final byte, which is the one where the current count steps from zero to all-ones. Without automatic reload, the channel then parks with a sticky done flag until the host writes a new count. With automatic reload, it restores its working address and count from the base values and stays ready for more work.

Top module: `dma_bus_channel`

## Requirements
- R1: After reset all outputs are low. On a request while idle and not done, `hold_req` rises. `addr_oe`, `dack` and every strobe stay low until `hold_ack` has been sampled high with `hold_req` asserted.
- R2: Each transfer takes exactly three cycles with `dack` and `addr_oe` high: setup, then one strobe cycle, then release. `addr_out` holds the same value across the setup and strobe cycles.
- R3: When mode bit 0 is 1 (I/O to memory), the strobe cycle asserts `io_rd` with `mem_wr`. When mode bit 0 is 0, it asserts `mem_rd` with `io_wr`. No other strobe combination occurs.
- R4: After every transfer the working address steps by one. It decrements when mode bit 1 is 1 and increments when it is 0, and it wraps modulo 2^16. Writing a new count does not change the working address.
- R5: A count of N yields N+1 transfers. `tc` is high only in the release cycle of the transfer made while the working count is zero.
- R6: With mode bit 2 at 0 (single), each service makes exactly one transfer and then `hold_req` drops.
- R7: With mode bit 2 at 1 (block), one request starts a run that continues without dropping `hold_req` until terminal count. `dreq` may fall once `dack` has been seen.
- R8: A pulse on `eop` during a transfer ends the service after that transfer.
- R9: With mode bit 3 at 1 (auto-reload), terminal count or `eop` reloads the working address and count from the base values at the end of the service, and `done` is not set.
- R10: With mode bit 3 at 0, terminal count sets `done`. While `done` is high, `dreq` is ignored and `hold_req` and `dack` stay low.
- R11: If `hold_ack` falls during a block, the current transfer completes. The bus is then released with `hold_req` kept high, and the run resumes at the next address once `hold_ack` returns.
- R12: `cfg_sel` 0 writes the base address and 1 writes the base count; either write also loads the working value one cycle later. A count write clears `done`. `cfg_sel` 2 writes the mode from `cfg_wdata[3:0]`. `cfg_sel` 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Host write strobe |
| cfg_sel | input | 2 | Host write target: 0 address, 1 count, 2 mode |
| cfg_wdata | input | 16 | Host write data |
| hold_req | output | 1 | Bus request to the processor |
| hold_ack | input | 1 | Bus grant from the processor |
| dreq | input | 1 | Peripheral transfer request |
| dack | output | 1 | Peripheral acknowledge, high during each transfer |
| eop | input | 1 | External end of service |
| tc | output | 1 | Terminal count pulse |
| done | output | 1 | Sticky completion flag |
| addr_out | output | 16 | Memory address |
| addr_oe | output | 1 | High while the controller drives the bus |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |

## Verification
The properties assume the following about the inputs:
- The processor grants `hold_ack` only while `hold_req` is high.
- The mode register is not rewritten while a service is in progress.
- `eop` is a short pulse that arrives inside a transfer.

The bench models the processor as a grant that follows `hold_req` one cycle later, with optional withdrawal windows. It programs the registers only between services and fires `eop` only in the strobe cycle of a chosen transfer. Randomised runs draw base, count and mode bits but keep reload off, so that each run ends with `done` set.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_REQ     = 3'd1,
        ST_SETUP   = 3'd2,
        ST_STROBE  = 3'd3,
        ST_RELEASE = 3'd4
    } dma_state_e;

    // mode word layout, bit 0 first: to_mem, decr, block, autoinit
    typedef struct packed {
        logic autoinit;
        logic block;
        logic decr;
        logic to_mem;
    } dma_mode_t;

    localparam logic [1:0] SEL_ADDR  = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_MODE  = 2'd2;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int WR_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [WR_W-1:0]   cfg_wdata,
    output logic [ADDR_W-1:0] base_addr,
    output logic [CNT_W-1:0]  base_cnt,
    output dma_mode_t         mode,
    output logic              ld_addr,
    output logic              ld_cnt
);

    localparam int MODE_W = $bits(dma_mode_t);

    typedef struct packed {
        logic [ADDR_W-1:0] base_addr;
        logic [CNT_W-1:0]  base_cnt;
        dma_mode_t         mode;
        logic              ld_addr;
        logic              ld_cnt;
    } cfg_t;

    cfg_t q, d;

    always_comb begin
        d         = q;
        d.ld_addr = 1'b0;
        d.ld_cnt  = 1'b0;
        if (cfg_we) begin
            case (cfg_sel)
                SEL_ADDR: begin
                    d.base_addr = cfg_wdata[ADDR_W-1:0];
                    d.ld_addr   = 1'b1;
                end
                SEL_COUNT: begin
                    d.base_cnt = cfg_wdata[CNT_W-1:0];
                    d.ld_cnt   = 1'b1;
                end
                SEL_MODE: begin
                    d.mode = dma_mode_t'(cfg_wdata[MODE_W-1:0]);
                end
                default: begin
                    d = q;
                    d.ld_addr = 1'b0;
                    d.ld_cnt  = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign base_addr = q.base_addr;
    assign base_cnt  = q.base_cnt;
    assign mode      = q.mode;
    assign ld_addr   = q.ld_addr;
    assign ld_cnt    = q.ld_cnt;

endmodule

// File: rtl/dma_addr_count.sv
module dma_addr_count #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_addr,
    input  logic              ld_cnt,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  base_cnt,
    input  logic              step,
    input  logic              decr,
    input  logic              reload,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cnt_zero
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
    } walk_t;

    walk_t q, d;

    always_comb begin
        d = q;
        if (reload) begin
            d.addr = base_addr;
            d.cnt  = base_cnt;
        end else begin
            if (step) begin
                d.addr = decr ? (q.addr - ADDR_ONE) : (q.addr + ADDR_ONE);
                d.cnt  = q.cnt - CNT_ONE;
            end
            if (ld_addr) begin
                d.addr = base_addr;
            end
            if (ld_cnt) begin
                d.cnt = base_cnt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cur_addr = q.addr;
    assign cnt_zero = (q.cnt == '0);

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
    import dma_chan_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      dreq,
    input  logic      hold_ack,
    input  logic      eop,
    input  dma_mode_t mode,
    input  logic      cnt_zero,
    input  logic      clr_done,
    output logic      hold_req,
    output logic      dack,
    output logic      bus_oe,
    output logic      mem_rd,
    output logic      mem_wr,
    output logic      io_rd,
    output logic      io_wr,
    output logic      tc,
    output logic      done,
    output logic      step,
    output logic      reload
);

    typedef struct packed {
        dma_state_e state;
        logic       eop_seen;
        logic       done;
    } fsm_t;

    fsm_t q, d;
    logic end_svc;
    logic in_xfer;
    logic strobe;

    always_comb begin
        d       = q;
        end_svc = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (dreq && !q.done) begin
                    d.state = ST_REQ;
                end
            end
            ST_REQ: begin
                if (hold_ack) begin
                    d.state = ST_SETUP;
                end
            end
            ST_SETUP: begin
                d.state    = ST_STROBE;
                d.eop_seen = q.eop_seen | eop;
            end
            ST_STROBE: begin
                d.state    = ST_RELEASE;
                d.eop_seen = q.eop_seen | eop;
            end
            ST_RELEASE: begin
                d.eop_seen = 1'b0;
                end_svc    = cnt_zero | q.eop_seen | eop;
                if (end_svc) begin
                    d.state = ST_IDLE;
                    if (cnt_zero && !mode.autoinit) begin
                        d.done = 1'b1;
                    end
                end else if (!mode.block) begin
                    d.state = ST_IDLE;
                end else if (hold_ack) begin
                    d.state = ST_SETUP;
                end else begin
                    d.state = ST_REQ;
                end
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
        if (clr_done) begin
            d.done = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, eop_seen: 1'b0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign in_xfer  = (q.state == ST_SETUP) || (q.state == ST_STROBE) ||
                      (q.state == ST_RELEASE);
    assign strobe   = (q.state == ST_STROBE);
    assign hold_req = (q.state != ST_IDLE);
    assign dack     = in_xfer;
    assign bus_oe   = in_xfer;
    assign mem_rd   = strobe && !mode.to_mem;
    assign io_wr    = strobe && !mode.to_mem;
    assign io_rd    = strobe && mode.to_mem;
    assign mem_wr   = strobe && mode.to_mem;
    assign tc       = (q.state == ST_RELEASE) && cnt_zero;
    assign step     = (q.state == ST_RELEASE);
    assign reload   = (q.state == ST_RELEASE) && end_svc && mode.autoinit;
    assign done     = q.done;

endmodule

// File: rtl/dma_bus_channel.sv
module dma_bus_channel
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int WR_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [WR_W-1:0]   cfg_wdata,
    output logic              hold_req,
    input  logic              hold_ack,
    input  logic              dreq,
    output logic              dack,
    input  logic              eop,
    output logic              tc,
    output logic              done,
    output logic [ADDR_W-1:0] addr_out,
    output logic              addr_oe,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              io_rd,
    output logic              io_wr
);

    logic [ADDR_W-1:0] base_addr;
    logic [CNT_W-1:0]  base_cnt;
    dma_mode_t         mode;
    logic              ld_addr;
    logic              ld_cnt;
    logic              step;
    logic              reload;
    logic              cnt_zero;
    logic              mode_block;

    dma_cfg_regs #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .WR_W   (WR_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .base_addr (base_addr),
        .base_cnt  (base_cnt),
        .mode      (mode),
        .ld_addr   (ld_addr),
        .ld_cnt    (ld_cnt)
    );

    dma_addr_count #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_addr   (ld_addr),
        .ld_cnt    (ld_cnt),
        .base_addr (base_addr),
        .base_cnt  (base_cnt),
        .step      (step),
        .decr      (mode.decr),
        .reload    (reload),
        .cur_addr  (addr_out),
        .cnt_zero  (cnt_zero)
    );

    dma_xfer_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .dreq     (dreq),
        .hold_ack (hold_ack),
        .eop      (eop),
        .mode     (mode),
        .cnt_zero (cnt_zero),
        .clr_done (ld_cnt),
        .hold_req (hold_req),
        .dack     (dack),
        .bus_oe   (addr_oe),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .io_rd    (io_rd),
        .io_wr    (io_wr),
        .tc       (tc),
        .done     (done),
        .step     (step),
        .reload   (reload)
    );

    assign mode_block = mode.block;

endmodule

// File: rtl/dma_bus_channel_chk.sv
module dma_bus_channel_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold_req,
    input logic              hold_ack,
    input logic              dack,
    input logic              tc,
    input logic              done,
    input logic [ADDR_W-1:0] addr_out,
    input logic              addr_oe,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              io_rd,
    input logic              io_wr,
    input logic              mode_block
);

    logic any_strobe;
    assign any_strobe = mem_rd | mem_wr | io_rd | io_wr;

    AST_GRANT_BEFORE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_oe) |-> $past(hold_ack)); // R1

    AST_STROBE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |-> (addr_oe && dack && hold_req)); // R2

    AST_STROBE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |=> (!any_strobe && dack && addr_oe)); // R2

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |-> $stable(addr_out)); // R2

    AST_READ_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (io_wr && !mem_wr && !io_rd)); // R3

    AST_WRITE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (io_rd && !mem_rd && !io_wr)); // R3

    AST_TC_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> $past(any_strobe)); // R5

    AST_SINGLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_block && $fell(dack)) |-> !hold_req); // R6

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!hold_req && !dack)); // R10

endmodule

bind dma_bus_channel dma_bus_channel_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_req   (hold_req),
    .hold_ack   (hold_ack),
    .dack       (dack),
    .tc         (tc),
    .done       (done),
    .addr_out   (addr_out),
    .addr_oe    (addr_oe),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .io_rd      (io_rd),
    .io_wr      (io_wr),
    .mode_block (mode_block)
);

// File: tb/dma_bus_channel_bench.sv
`timescale 1ns/1ps
module dma_bus_channel_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'h0;
    logic        hold_req;
    logic        hold_ack = 1'b0;
    logic        dreq = 1'b0;
    logic        dack;
    logic        eop = 1'b0;
    logic        tc;
    logic        done;
    logic [15:0] addr_out;
    logic        addr_oe;
    logic        mem_rd, mem_wr, io_rd, io_wr;

    always #2 clk = ~clk;

    dma_bus_channel u_dma_bus_channel (
        .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_sel (cfg_sel),
        .cfg_wdata (cfg_wdata), .hold_req (hold_req), .hold_ack (hold_ack),
        .dreq (dreq), .dack (dack), .eop (eop), .tc (tc), .done (done),
        .addr_out (addr_out), .addr_oe (addr_oe), .mem_rd (mem_rd),
        .mem_wr (mem_wr), .io_rd (io_rd), .io_wr (io_wr)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // observer and processor model
    logic [15:0] rec_addr [0:1023];
    bit          rec_mem  [0:1023];
    bit          rec_tc   [0:1023];
    int  nrec = 0;
    int  hold_falls = 0;
    int  oe_noack = 0;
    int  seq_bad = 0;
    int  eop_at = -1;
    int  drop_at = -1;
    int  drop_len = 0;
    int  blk_cnt = 0;
    bit  ack_off = 1'b0;

    initial begin
        bit prev_strb = 1'b0;
        bit prev_hold = 1'b0;
        forever begin
            @(negedge clk);
            begin
                bit strb;
                strb = mem_rd | mem_wr | io_rd | io_wr;
                if (prev_strb) begin
                    if (nrec > 0) rec_tc[(nrec-1)%1024] = tc;
                    if (!(dack && addr_oe && !strb)) seq_bad++;
                end
                eop = 1'b0;
                if (strb) begin
                    if (!(dack && addr_oe)) seq_bad++;
                    if (!((mem_rd && io_wr && !mem_wr && !io_rd) ||
                          (mem_wr && io_rd && !mem_rd && !io_wr))) seq_bad++;
                    rec_addr[nrec%1024] = addr_out;
                    rec_mem[nrec%1024]  = mem_wr;
                    rec_tc[nrec%1024]   = 1'b0;
                    nrec++;
                    if (nrec == eop_at) eop = 1'b1;
                    if (nrec == drop_at) blk_cnt = drop_len;
                end
                if (prev_hold && !hold_req) hold_falls++;
                if (addr_oe && !hold_ack) oe_noack++;
                prev_hold = hold_req;
                prev_strb = strb;
                if (blk_cnt > 0) begin
                    hold_ack = 1'b0;
                    blk_cnt--;
                end else begin
                    hold_ack = hold_req && !ack_off;
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    function automatic logic [15:0] exp_addr(input logic [15:0] b, input int k, input bit decr);
        return decr ? (b - 16'(k)) : (b + 16'(k));
    endfunction

    task automatic prog(input logic [1:0] sel, input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic service(input string rq);
        int t;
        @(negedge clk);
        dreq = 1'b1;
        t = 0;
        while (!dack && t < 300) begin @(negedge clk); t++; end
        dreq = 1'b0;
        if (t >= 300) chk(1'b0, rq, "no acknowledge", 0, 1);
        t = 0;
        while (hold_req && t < 3000) begin @(negedge clk); t++; end
        repeat (3) @(negedge clk);
    endtask

    task automatic check_run(input string rq, input int first, input int n,
                             input logic [15:0] base, input bit decr, input bit to_mem,
                             input bit tc_last);
        chk(nrec - first == n, rq, "transfer count", nrec - first, n);
        for (int k = 0; k < n && k < nrec - first; k++) begin
            int i;
            i = (first + k) % 1024;
            chk(rec_addr[i] == exp_addr(base, k, decr), "R4", "address",
                rec_addr[i], exp_addr(base, k, decr));
            chk(rec_mem[i] == to_mem, "R3", "direction", rec_mem[i], to_mem);
            chk(rec_tc[i] == (tc_last && k == n - 1), "R5", "terminal count",
                rec_tc[i], (tc_last && k == n - 1));
        end
    endtask

    initial begin
        int first;
        int f0;
        int o0;
        bit seen_bus;
        bit seen_req;
        void'($urandom(32'h5eed1234));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk({hold_req, dack, addr_oe, mem_rd, mem_wr, io_rd, io_wr, tc, done} == '0,
            "R1", "reset outputs",
            {hold_req, dack, addr_oe, mem_rd, mem_wr, io_rd, io_wr, tc, done}, 0);

        // single mode, memory to I/O, increment, count 2
        prog(2'd0, 16'h1000);
        prog(2'd1, 16'd2);
        prog(2'd2, 16'h0000);
        first = nrec;
        f0 = hold_falls;
        for (int s = 0; s < 3; s++) begin
            service("R6");
            chk(nrec - first == s + 1, "R6", "one transfer per service", nrec - first, s + 1);
        end
        chk(hold_falls - f0 == 3, "R6", "hold drops per service", hold_falls - f0, 3);
        check_run("R5", first, 3, 16'h1000, 1'b0, 1'b0, 1'b1);
        chk(done == 1'b1, "R10", "done after terminal count", done, 1);

        // R10: requests ignored while done
        first = nrec;
        seen_req = 1'b0;
        dreq = 1'b1;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            seen_req |= hold_req | dack;
        end
        dreq = 1'b0;
        chk(!seen_req && nrec == first, "R10", "request while done", seen_req, 0);

        // R12: count write clears done; R4: address continues
        prog(2'd1, 16'd0);
        chk(done == 1'b0, "R12", "done cleared by count write", done, 0);
        first = nrec;
        service("R4");
        check_run("R4", first, 1, 16'h1003, 1'b0, 1'b0, 1'b1);

        // block, I/O to memory, decrement across zero
        prog(2'd0, 16'h0002);
        prog(2'd1, 16'd4);
        prog(2'd2, 16'h0007);
        first = nrec;
        f0 = hold_falls;
        service("R7");
        check_run("R7", first, 5, 16'h0002, 1'b1, 1'b1, 1'b1);
        chk(hold_falls - f0 == 1, "R7", "hold kept for block", hold_falls - f0, 1);
        chk(done == 1'b1, "R10", "done after block", done, 1);

        // EOP with auto-reload in block mode
        prog(2'd0, 16'h4000);
        prog(2'd1, 16'd100);
        prog(2'd2, 16'h000C);
        first = nrec;
        eop_at = nrec + 3;
        service("R8");
        eop_at = -1;
        check_run("R8", first, 3, 16'h4000, 1'b0, 1'b0, 1'b0);
        chk(done == 1'b0, "R9", "no done after end-of-process", done, 0);
        first = nrec;
        eop_at = nrec + 2;
        service("R9");
        eop_at = -1;
        check_run("R9", first, 2, 16'h4000, 1'b0, 1'b0, 1'b0);

        // auto-reload on terminal count; unused select has no effect
        prog(2'd0, 16'h0010);
        prog(2'd1, 16'd1);
        prog(2'd2, 16'h000D);
        first = nrec;
        service("R9");
        check_run("R9", first, 2, 16'h0010, 1'b0, 1'b1, 1'b1);
        chk(done == 1'b0, "R9", "no done with reload", done, 0);
        prog(2'd3, 16'h0000);
        first = nrec;
        service("R12");
        check_run("R12", first, 2, 16'h0010, 1'b0, 1'b1, 1'b1);

        // grant lost mid-block
        prog(2'd0, 16'h3000);
        prog(2'd1, 16'd5);
        prog(2'd2, 16'h0004);
        first = nrec;
        f0 = hold_falls;
        o0 = oe_noack;
        drop_at = nrec + 2;
        drop_len = 6;
        service("R11");
        drop_at = -1;
        check_run("R11", first, 6, 16'h3000, 1'b0, 1'b0, 1'b1);
        chk(hold_falls - f0 == 1, "R11", "hold kept through lost grant", hold_falls - f0, 1);
        chk(oe_noack - o0 == 1, "R11", "bus cycles without grant", oe_noack - o0, 1);

        // R1: no bus activity while grant withheld
        prog(2'd1, 16'd0);
        ack_off = 1'b1;
        seen_bus = 1'b0;
        seen_req = 1'b0;
        first = nrec;
        @(negedge clk);
        dreq = 1'b1;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            seen_req |= hold_req;
            seen_bus |= addr_oe | dack | mem_rd | mem_wr | io_rd | io_wr;
        end
        chk(seen_req && !seen_bus, "R1", "bus idle before grant", {seen_req, seen_bus}, 2);
        ack_off = 1'b0;
        begin
            int t;
            t = 0;
            while (!dack && t < 100) begin @(negedge clk); t++; end
            dreq = 1'b0;
            t = 0;
            while (hold_req && t < 100) begin @(negedge clk); t++; end
            repeat (3) @(negedge clk);
        end
        check_run("R1", first, 1, 16'h3006, 1'b0, 1'b0, 1'b1);

        // randomised runs, reload off
        for (int r = 0; r < 24; r++) begin
            logic [15:0] b;
            int          n;
            logic [2:0]  m;
            int          s;
            b = 16'($urandom);
            n = $urandom_range(0, 6);
            m = 3'($urandom);
            prog(2'd0, b);
            prog(2'd1, 16'(n));
            prog(2'd2, {13'd0, m});
            first = nrec;
            s = 0;
            while (!done && s < 20) begin
                service("R5");
                s++;
            end
            check_run("R5", first, n + 1, b, m[1], m[0], 1'b1);
            chk(done == 1'b1, "R10", "done after random run", done, 1);
        end

        chk(seq_bad == 0, "R2", "transfer cycle shape", seq_bad, 0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule